// File: doc/BRIEF.md
# Split-Lane Command and Data Link Controller

This block sits between a compute accelerator and one x8 DRAM device and drives the eight wires between them. The wires are divided once, at elaboration time, into two fixed groups. `DATA_LANES` wires (4, 5 or 6) carry data only, and the remaining `8 - DATA_LANES` wires carry command and address only. Because no wire ever changes role, a command can be shifted out on the command group while the data of the previous transfer is still moving on the data group. No turnaround bubble is ever needed.

Requests (activate, precharge, read, write) arrive on a valid/ready port. Each command word is `{addr, bank, op}`. It is serialized least significant bits first over the command wires, one beat per cycle. A 64-bit write word is packed onto the data wires in `ceil(64/DATA_LANES)` beats, and read beats coming back from the device are reassembled into one 64-bit response. Fewer data wires give more beats: 11 beats for 6 wires, 13 for 5 and 16 for 4. DRAM timing and refresh belong to the surrounding controller.

Three state machines do the work:
- **Command serializer**: states `C_IDLE` and `C_SHIFT`. `C_IDLE` moves to `C_SHIFT` when a request is loaded. `C_SHIFT` returns to `C_IDLE` on its last beat.
- **Data engine**: states `D_IDLE`, `D_WRITE` and `D_READ`. `D_IDLE` moves to `D_WRITE` on a write start and to `D_READ` on a read start. `D_WRITE` returns to `D_IDLE` after its last driven beat. `D_READ` returns to `D_IDLE` after its last captured beat.
- **Pending-job slot in the top**: states `P_EMPTY`, `P_WAIT_CMD` and `P_ARMED`.
  - `P_EMPTY` moves to `P_WAIT_CMD` when a read or write is accepted.
  - `P_WAIT_CMD` moves to `P_EMPTY` when the command's last beat coincides with an idle data engine.
  - `P_WAIT_CMD` moves to `P_ARMED` when the command's last beat finds the data engine busy.
  - `P_ARMED` moves to `P_EMPTY` once the data engine is idle.

Top module: `splitlane_link`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `cmd_valid_o`, `dq_oe` and `rsp_valid` are 0.
- R2: An accepted request produces `ceil(18/CMD_LANES)` command beats on consecutive cycles, starting the cycle after acceptance, with `cmd_valid_o` high on each of them. Beat k carries bits `[k*CMD_LANES +: CMD_LANES]` of the zero-padded word `{addr[13:0], bank[1:0], op[1:0]}`. The op encoding is activate=00, precharge=01, read=10, write=11.
- R3: Activate and precharge requests move no data: `dq_oe` stays 0 and `rsp_valid` stays 0.
- R4: For a write whose data group is free, the data beats start in the cycle right after the last command beat. There are `ceil(64/DATA_LANES)` of them on consecutive cycles with `dq_oe` high. Beat k carries bits `[k*DATA_LANES +: DATA_LANES]` of the write word, and the padding bits above bit 63 in the final beat are 0.
- R5: During a read, the k-th cycle with `dq_in_valid` high supplies bits `[k*DATA_LANES +: DATA_LANES]` of the result, and cycles with `dq_in_valid` low are skipped. One cycle after the final beat, `rsp_valid` pulses for exactly one cycle with the 64-bit word. Received padding bits above bit 63 are discarded.
- R6: `dq_in_valid` pulses while no read is in progress produce no response and do not disturb the data of the next read.
- R7: A new request may be accepted and serialized on the command wires while the previous write's data beats are still being driven.
- R8: `req_ready` is 0 while a command is being serialized and while an accepted read or write still waits for the data group. A waiting write starts its beats two cycles after the last beat of the read ahead of it, which is one cycle after that read's `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 00 activate, 01 precharge, 10 read, 11 write |
| req_bank | input | BANK_W | Bank number |
| req_addr | input | ADDR_W | Row or column address |
| req_wdata | input | XFER_W | Write word |
| rsp_valid | output | 1 | One-cycle pulse with read result |
| rsp_data | output | XFER_W | Reassembled read word |
| cmd_lanes_o | output | 8-DATA_LANES | Command/address wires |
| cmd_valid_o | output | 1 | High on each command beat |
| dq_out | output | DATA_LANES | Data wires, driven value |
| dq_oe | output | 1 | Data wires driven by this block |
| dq_in | input | DATA_LANES | Data wires, received value |
| dq_in_valid | input | 1 | A received read beat is present |

## Verification
The assertions assume that the device only returns read beats when a read has been issued. They also assume that `req_valid` is held steady until accepted and that `req_op` is a legal two-bit code. The stimulus changes inputs only on falling clock edges. It raises a request only when `req_ready` is seen high and drops it right after the accepting edge. It drives stray `dq_in_valid` pulses only in the one directed case that probes R6, where no read is outstanding.

// File: rtl/splitlane_pkg.sv
`timescale 1ns/1ps
package splitlane_pkg;
    typedef enum logic [1:0] {
        OP_ACT = 2'b00,
        OP_PRE = 2'b01,
        OP_RD  = 2'b10,
        OP_WR  = 2'b11
    } link_op_e;

    function automatic int beats_for(input int bits, input int lanes);
        return (bits + lanes - 1) / lanes;
    endfunction
endpackage

// File: rtl/splitlane_cmd_ser.sv
`timescale 1ns/1ps
module splitlane_cmd_ser #(
    parameter int CMD_W = 18,
    parameter int CL    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CMD_W-1:0] load_word,
    output logic             idle,
    output logic             last_beat,
    output logic             beat_valid,
    output logic [CL-1:0]    lanes
);
    import splitlane_pkg::*;

    localparam int CBEATS = beats_for(CMD_W, CL);
    localparam int SHW    = CBEATS * CL;
    localparam int CW     = $clog2(CBEATS + 1);
    localparam logic [CW-1:0] LASTC = CW'(CBEATS - 1);

    typedef enum logic {C_IDLE, C_SHIFT} cstate_e;

    cstate_e         state, state_nxt;
    logic [SHW-1:0]  shreg;
    logic [CW-1:0]   cnt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            C_IDLE:  if (load) state_nxt = C_SHIFT;
            C_SHIFT: if (cnt == LASTC) state_nxt = C_IDLE;
            default: state_nxt = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= C_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (state == C_IDLE) begin
            if (load) begin
                shreg <= SHW'(load_word);
                cnt   <= '0;
            end
        end else begin
            shreg <= shreg >> CL;
            cnt   <= cnt + 1'b1;
        end
    end

    always_comb begin
        idle       = (state == C_IDLE);
        beat_valid = (state == C_SHIFT);
        last_beat  = (state == C_SHIFT) && (cnt == LASTC);
        lanes      = beat_valid ? shreg[CL-1:0] : '0;
    end
endmodule

// File: rtl/splitlane_data_eng.sv
`timescale 1ns/1ps
module splitlane_data_eng #(
    parameter int XW = 64,
    parameter int DL = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_wr,
    input  logic          start_rd,
    input  logic [XW-1:0] wdata,
    output logic          idle,
    output logic [DL-1:0] dq_out,
    output logic          dq_oe,
    input  logic [DL-1:0] dq_in,
    input  logic          dq_in_valid,
    output logic          rsp_valid,
    output logic [XW-1:0] rsp_data
);
    import splitlane_pkg::*;

    localparam int DBEATS = beats_for(XW, DL);
    localparam int PADW   = DBEATS * DL;
    localparam int CW     = $clog2(DBEATS + 1);
    localparam logic [CW-1:0] LASTD = CW'(DBEATS - 1);

    typedef enum logic [1:0] {D_IDLE, D_WRITE, D_READ} dstate_e;

    dstate_e         state, state_nxt;
    logic [PADW-1:0] shreg;
    logic [CW-1:0]   cnt;
    logic            rd_take;
    logic            rd_last;

    assign rd_take = (state == D_READ) && dq_in_valid;
    assign rd_last = rd_take && (cnt == LASTD);

    always_comb begin
        state_nxt = state;
        unique case (state)
            D_IDLE: begin
                if (start_wr)      state_nxt = D_WRITE;
                else if (start_rd) state_nxt = D_READ;
            end
            D_WRITE: if (cnt == LASTD) state_nxt = D_IDLE;
            D_READ:  if (rd_last)      state_nxt = D_IDLE;
            default: state_nxt = D_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= D_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_last;
            unique case (state)
                D_IDLE: begin
                    cnt <= '0;
                    if (start_wr)      shreg <= PADW'(wdata);
                    else if (start_rd) shreg <= '0;
                end
                D_WRITE: begin
                    shreg <= shreg >> DL;
                    cnt   <= cnt + 1'b1;
                end
                D_READ: begin
                    if (rd_take) begin
                        shreg <= {dq_in, shreg[PADW-1:DL]};
                        cnt   <= cnt + 1'b1;
                    end
                    if (rd_last) rsp_data <= XW'({dq_in, shreg[PADW-1:DL]});
                end
                default: cnt <= '0;
            endcase
        end
    end

    always_comb begin
        idle   = (state == D_IDLE);
        dq_oe  = (state == D_WRITE);
        dq_out = dq_oe ? shreg[DL-1:0] : '0;
    end
endmodule

// File: rtl/splitlane_link.sv
`timescale 1ns/1ps
module splitlane_link #(
    parameter int TOTAL_LANES = 8,
    parameter int DATA_LANES  = 6,
    parameter int BANK_W      = 2,
    parameter int ADDR_W      = 14,
    parameter int XFER_W      = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic [1:0]                        req_op,
    input  logic [BANK_W-1:0]                 req_bank,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [XFER_W-1:0]                 req_wdata,
    output logic                              rsp_valid,
    output logic [XFER_W-1:0]                 rsp_data,
    output logic [TOTAL_LANES-DATA_LANES-1:0] cmd_lanes_o,
    output logic                              cmd_valid_o,
    output logic [DATA_LANES-1:0]             dq_out,
    output logic                              dq_oe,
    input  logic [DATA_LANES-1:0]             dq_in,
    input  logic                              dq_in_valid
);
    import splitlane_pkg::*;

    localparam int CMD_LANES = TOTAL_LANES - DATA_LANES;
    localparam int CMD_W     = 2 + BANK_W + ADDR_W;

    typedef enum logic [1:0] {P_EMPTY, P_WAIT_CMD, P_ARMED} pstate_e;

    pstate_e           pstate, pstate_nxt;
    logic              pend_is_wr;
    logic [XFER_W-1:0] pend_wdata;
    logic              cmd_idle, cmd_last;
    logic              data_idle;
    logic              accept, needs_data, start;

    assign needs_data = (req_op == OP_RD) || (req_op == OP_WR);
    assign accept     = req_valid && req_ready;
    assign start      = data_idle && ((pstate == P_ARMED) ||
                                      ((pstate == P_WAIT_CMD) && cmd_last));

    always_comb begin
        pstate_nxt = pstate;
        unique case (pstate)
            P_EMPTY:    if (accept && needs_data) pstate_nxt = P_WAIT_CMD;
            P_WAIT_CMD: begin
                if (start)         pstate_nxt = P_EMPTY;
                else if (cmd_last) pstate_nxt = P_ARMED;
            end
            P_ARMED:    if (start) pstate_nxt = P_EMPTY;
            default:    pstate_nxt = P_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pstate <= P_EMPTY;
        else        pstate <= pstate_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_is_wr <= 1'b0;
            pend_wdata <= '0;
        end else if (accept && needs_data) begin
            pend_is_wr <= (req_op == OP_WR);
            pend_wdata <= req_wdata;
        end
    end

    always_comb begin
        req_ready = cmd_idle && (pstate == P_EMPTY);
    end

    splitlane_cmd_ser #(
        .CMD_W (CMD_W),
        .CL    (CMD_LANES)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_word  ({req_addr, req_bank, req_op}),
        .idle       (cmd_idle),
        .last_beat  (cmd_last),
        .beat_valid (cmd_valid_o),
        .lanes      (cmd_lanes_o)
    );

    splitlane_data_eng #(
        .XW (XFER_W),
        .DL (DATA_LANES)
    ) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (start && pend_is_wr),
        .start_rd    (start && !pend_is_wr),
        .wdata       (pend_wdata),
        .idle        (data_idle),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .dq_in       (dq_in),
        .dq_in_valid (dq_in_valid),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );
endmodule

// File: rtl/splitlane_link_chk.sv
`timescale 1ns/1ps
module splitlane_link_chk #(
    parameter int TOTAL_LANES = 8,
    parameter int DATA_LANES  = 6,
    parameter int BANK_W      = 2,
    parameter int ADDR_W      = 14,
    parameter int XFER_W      = 64
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic cmd_valid_o,
    input logic dq_oe
);
    import splitlane_pkg::*;

    localparam int CBEATS = beats_for(2 + BANK_W + ADDR_W, TOTAL_LANES - DATA_LANES);
    localparam int DBEATS = beats_for(XFER_W, DATA_LANES);

    logic [7:0] cmd_run, oe_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_run <= '0;
            oe_run  <= '0;
        end else begin
            cmd_run <= cmd_valid_o ? cmd_run + 8'd1 : 8'd0;
            oe_run  <= dq_oe       ? oe_run  + 8'd1 : 8'd0;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !cmd_valid_o && !dq_oe && !rsp_valid));

    p_accept_shifts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> cmd_valid_o);

    p_cmd_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_run < 8'(CBEATS)));

    p_cmd_len_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid_o && cmd_run != 8'd0) |-> (cmd_run == 8'(CBEATS)));

    p_wr_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_run < 8'(DBEATS)));

    p_wr_len_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dq_oe && oe_run != 8'd0) |-> (oe_run == 8'(DBEATS)));

    p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !req_ready);
endmodule

bind splitlane_link splitlane_link_chk #(
    .TOTAL_LANES (TOTAL_LANES),
    .DATA_LANES  (DATA_LANES),
    .BANK_W      (BANK_W),
    .ADDR_W      (ADDR_W),
    .XFER_W      (XFER_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .cmd_valid_o (cmd_valid_o),
    .dq_oe       (dq_oe)
);

// File: tb/splitlane_link_test.sv
`timescale 1ns/1ps
module splitlane_link_test;
    localparam int CLK_PERIOD = 10;
    localparam int DL     = 6;
    localparam int CL     = 8 - DL;
    localparam int CBEATS = (18 + CL - 1) / CL;
    localparam int DBEATS = (64 + DL - 1) / DL;
    localparam int PADW   = DBEATS * DL;
    localparam int CMDSH  = CBEATS * CL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = '0;
    logic [1:0] req_bank = '0;
    logic [13:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid;
    logic [63:0] rsp_data;
    logic [CL-1:0] cmd_lanes_o;
    logic cmd_valid_o;
    logic [DL-1:0] dq_out;
    logic dq_oe;
    logic [DL-1:0] dq_in = '0;
    logic dq_in_valid = 1'b0;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;

    logic [4*CMDSH-1:0] mon_cmd;
    int mon_cmd_n, mon_cmd_first, mon_cmd_last;
    logic [2*PADW-1:0] mon_wr;
    int mon_wr_n, mon_wr_first;
    int mon_rsp_n, mon_rsp_cyc;
    logic [63:0] mon_rsp;
    bit mon_overlap;

    splitlane_link #(.DATA_LANES(DL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .cmd_lanes_o(cmd_lanes_o), .cmd_valid_o(cmd_valid_o),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .dq_in_valid(dq_in_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cmd_valid_o) begin
            if (mon_cmd_n < 4*CBEATS) mon_cmd[mon_cmd_n*CL +: CL] = cmd_lanes_o;
            if (mon_cmd_n == 0) mon_cmd_first = cyc;
            mon_cmd_last = cyc;
            mon_cmd_n++;
        end
        if (dq_oe) begin
            if (mon_wr_n < 2*DBEATS) mon_wr[mon_wr_n*DL +: DL] = dq_out;
            if (mon_wr_n == 0) mon_wr_first = cyc;
            mon_wr_n++;
        end
        if (dq_oe && cmd_valid_o) mon_overlap = 1;
        if (rsp_valid) begin
            mon_rsp_n++;
            mon_rsp = rsp_data;
            mon_rsp_cyc = cyc;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: cycle %0d reached, expected end before %0d", cyc, 20000);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        mon_cmd = '0; mon_cmd_n = 0; mon_cmd_first = -1; mon_cmd_last = -1;
        mon_wr = '0; mon_wr_n = 0; mon_wr_first = -1;
        mon_rsp_n = 0; mon_rsp_cyc = -1; mon_rsp = '0; mon_overlap = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [1:0] bank,
                            input logic [13:0] addr, input logic [63:0] wd,
                            output int acc);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_op = op; req_bank = bank; req_addr = addr; req_wdata = wd;
        acc = cyc;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic feed_read(input logic [63:0] data, input bit gap, output int last_cyc);
        logic [PADW-1:0] pad;
        pad = '1;
        pad[63:0] = data;
        for (int k = 0; k < DBEATS; k++) begin
            if (gap && k == 5) begin
                dq_in_valid = 0; dq_in = '1;
                @(negedge clk);
            end
            dq_in = pad[k*DL +: DL];
            dq_in_valid = 1;
            last_cyc = cyc;
            @(negedge clk);
        end
        dq_in_valid = 0;
        dq_in = '0;
    endtask

    task automatic check_cmd(input string req, input logic [1:0] op, input logic [1:0] bank,
                             input logic [13:0] addr, input int acc);
        chk(req, "cmd beat count", 128'(mon_cmd_n), 128'(CBEATS));
        chk(req, "cmd word", 128'(mon_cmd[CMDSH-1:0]), 128'({addr, bank, op}));
        chk(req, "cmd first beat cycle", 128'(mon_cmd_first), 128'(acc + 1));
    endtask

    task automatic t_reset();
        chk("R1", "ready in reset", 128'(req_ready), 128'(1));
        chk("R1", "quiet in reset", 128'({cmd_valid_o, dq_oe, rsp_valid}), 128'(0));
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "ready after reset", 128'(req_ready), 128'(1));
        chk("R1", "quiet after reset", 128'({cmd_valid_o, dq_oe, rsp_valid}), 128'(0));
    endtask

    task automatic t_act_pre();
        int acc;
        clear_mon();
        send_cmd(2'b00, 2'd2, 14'h2A5C, 64'hFFFF_FFFF_FFFF_FFFF, acc);
        idle(CBEATS + 4);
        check_cmd("R2", 2'b00, 2'd2, 14'h2A5C, acc);
        chk("R3", "activate write beats", 128'(mon_wr_n), 128'(0));
        chk("R3", "activate responses", 128'(mon_rsp_n), 128'(0));
        clear_mon();
        send_cmd(2'b01, 2'd1, 14'h3FFF, 64'h1234, acc);
        idle(CBEATS + 4);
        check_cmd("R2", 2'b01, 2'd1, 14'h3FFF, acc);
        chk("R3", "precharge write beats", 128'(mon_wr_n), 128'(0));
    endtask

    task automatic t_write(input logic [63:0] wd);
        int acc;
        clear_mon();
        send_cmd(2'b11, 2'd3, 14'h0155, wd, acc);
        idle(CBEATS + DBEATS + 4);
        check_cmd("R2", 2'b11, 2'd3, 14'h0155, acc);
        chk("R4", "write beat count", 128'(mon_wr_n), 128'(DBEATS));
        chk("R4", "write first beat cycle", 128'(mon_wr_first), 128'(mon_cmd_last + 1));
        chk("R4", "write data", 128'(mon_wr[PADW-1:0]), 128'({{(PADW-64){1'b0}}, wd}));
    endtask

    task automatic t_read(input logic [63:0] rd, input bit gap);
        int acc, lc;
        clear_mon();
        send_cmd(2'b10, 2'd0, 14'h1001, 64'h0, acc);
        wait (mon_cmd_n == CBEATS);
        @(negedge clk);
        feed_read(rd, gap, lc);
        idle(3);
        chk("R5", "read response count", 128'(mon_rsp_n), 128'(1));
        chk("R5", "read response data", 128'(mon_rsp), 128'(rd));
        chk("R5", "read response cycle", 128'(mon_rsp_cyc), 128'(lc + 1));
        chk("R3", "read drives no data", 128'(mon_wr_n), 128'(0));
    endtask

    task automatic t_stray();
        clear_mon();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            dq_in = DL'(6'h2B + i); dq_in_valid = 1;
        end
        @(negedge clk);
        dq_in_valid = 0; dq_in = '0;
        idle(3);
        chk("R6", "stray beats give no response", 128'(mon_rsp_n), 128'(0));
        t_read(64'h0BAD_CAFE_1357_9BDF, 0);
    endtask

    task automatic t_overlap();
        int acc, acc2;
        clear_mon();
        send_cmd(2'b11, 2'd1, 14'h0AAA, 64'h5555_AAAA_0F0F_F0F0, acc);
        send_cmd(2'b00, 2'd2, 14'h0033, 64'h0, acc2);
        idle(DBEATS + CBEATS + 4);
        chk("R7", "command during write beats", 128'(mon_overlap), 128'(1));
        chk("R7", "second command accepted while writing", 128'(acc2 < mon_wr_first + DBEATS), 128'(1));
        chk("R7", "second command word", 128'(mon_cmd[2*CMDSH-1:CMDSH]), 128'({14'h0033, 2'd2, 2'b00}));
        chk("R7", "write data intact", 128'(mon_wr[63:0]), 128'(64'h5555_AAAA_0F0F_F0F0));
    endtask

    task automatic t_backpressure();
        int acc, acc2, lc;
        clear_mon();
        send_cmd(2'b10, 2'd0, 14'h0007, 64'h0, acc);
        send_cmd(2'b11, 2'd3, 14'h0008, 64'hDEAD_BEEF_0000_0001, acc2);
        wait (mon_cmd_n == 2*CBEATS);
        idle(3);
        chk("R8", "ready low while write waits", 128'(req_ready), 128'(0));
        chk("R8", "waiting write not driven", 128'(mon_wr_n), 128'(0));
        feed_read(64'h0123_4567_89AB_CDEF, 1, lc);
        idle(DBEATS + 4);
        chk("R5", "read with gap data", 128'(mon_rsp), 128'(64'h0123_4567_89AB_CDEF));
        chk("R8", "write starts after read", 128'(mon_wr_first), 128'(mon_rsp_cyc + 1));
        chk("R8", "queued write data", 128'(mon_wr[63:0]), 128'(64'hDEAD_BEEF_0000_0001));
        chk("R8", "ready again", 128'(req_ready), 128'(1));
    endtask

    initial begin
        clear_mon();
        idle(3);
        t_reset();
        t_act_pre();
        t_write(64'hFEDC_BA98_7654_3210);
        t_write(64'hFFFF_FFFF_FFFF_FFFF);
        t_read(64'hA5A5_5A5A_C3C3_3C3C, 0);
        t_stray();
        t_overlap();
        t_backpressure();
        idle(2);
        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end
endmodule